// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit sits in front of a small word-addressed memory that several cores share. It performs each request as one indivisible operation. A core presents an operation code, a word address, a compare value and a new value. The unit reads the addressed word and compares it with the compare value. When the two are equal it writes the new value back. It then returns the word it read together with a success flag, so a core can spin on a failed attempt and retry with fresh data. The same path also serves plain loads, plain stores and a test-and-set variant. In the test-and-set variant, both the compare operand and the store operand are forced to one.

Each core has its own request port with a valid/ready handshake. A fixed-priority arbiter picks one waiting port at a time, and the lowest port index has the highest priority. Once a request is accepted, every ready line stays low until the operation has finished. The read, compare and write phases of one operation therefore cannot be split by any other access. A core holds its request stable while its valid is high and its ready is low. Ready is asserted only to the port the arbiter picks, and only while the unit is idle.

Responses are a single-cycle pulse on the owner's response-valid line. Result data and the success flag are shared by all ports. A response cannot be back-pressured, so a requester must take it in the cycle it appears. The memory is an internal register array cleared to zero by reset.

Top module: `atomic_cas_unit`

## Requirements
- R1: After reset every memory word reads as zero, no response-valid line is high, and no ready line is high while no request is valid.
- R2: A compare-and-swap (op code 2) whose compare value equals the stored word writes the new value, returns the old word, and sets the success flag to 1.
- R3: A compare-and-swap whose compare value differs from the stored word leaves the word unchanged, returns the old word, and sets the success flag to 0.
- R4: A test-and-set (op code 3) ignores the compare and new-value inputs and uses one for both. It succeeds only when the word holds 1, it returns the old word, and the word afterwards never holds the supplied new value.
- R5: A load (op code 0) returns the stored word with the success flag set to 1 and writes nothing.
- R6: A store (op code 1) writes the new value unconditionally, returns the old word, and sets the success flag to 1; this includes the highest address.
- R7: Of the ports with a valid request, only the lowest-numbered one sees ready, so at most one ready line is high at a time.
- R8: From the acceptance edge until the response has been given, every ready line is low, so no other port can reach the memory.
- R9: The response-valid line of the accepting port is high for exactly one cycle. That cycle is the third clock cycle after the acceptance edge. No other port's response-valid line is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request valid |
| req_ready | output | NUM_PORTS | Per-port request ready (grant while idle) |
| req_op | input | 2*NUM_PORTS | Per-port op: 0 load, 1 store, 2 compare-and-swap, 3 test-and-set |
| req_addr | input | ADDR_W*NUM_PORTS | Per-port word address |
| req_cmp | input | DATA_W*NUM_PORTS | Per-port compare value |
| req_new | input | DATA_W*NUM_PORTS | Per-port new value |
| rsp_valid | output | NUM_PORTS | One-cycle response pulse to the owning port |
| rsp_data | output | DATA_W | Word read before any write |
| rsp_ok | output | 1 | Success flag |

## Verification
The bench drives a compare-and-swap that must fail right after one that succeeded on the same word. A unit that compared against a stale or forwarded value would overwrite the word there. Test-and-set is given non-one compare and new operands; a unit that passed those operands through would store 5 and report the wrong success flag. Two ports request in the same cycle, and the ready lines are then sampled throughout the operation. A unit with the wrong priority would grant port 2 first, and one that released the lock early would show ready before the response. The response is also timed: a unit that added or dropped a phase would raise response-valid on the wrong cycle.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CAS   = 2'd2,
    OP_TAS   = 2'd3
  } atom_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CMP   = 2'd2,
    ST_WRITE = 2'd3
  } atom_st_e;
endpackage

// File: rtl/atom_prio_arb.sv
module atom_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_arb
    assign seen[i+1] = seen[i] | req[i];
    assign gnt[i]    = req[i] & ~seen[i];
  end
endmodule

// File: rtl/atom_word_mem.sv
module atom_word_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) words[wr_addr] <= wr_data;
      if (rd_en) rd_data <= words[rd_addr];
    end
  end
endmodule

// File: rtl/atom_seq.sv
module atom_seq
  import atom_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [PW-1:0] in_port,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_cmp,
  input  logic [DW-1:0] in_new,
  output logic          idle,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_fire,
  output logic [PW-1:0] rsp_port,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ok
);
  atom_st_e      st_q;
  atom_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmp_q, new_q, old_q;
  logic [PW-1:0] port_q;
  logic          do_wr_q, ok_q;
  logic          same;

  assign same = (mem_rdata == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      cmp_q   <= '0;
      new_q   <= '0;
      old_q   <= '0;
      port_q  <= '0;
      do_wr_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_q   <= atom_op_e'(in_op);
          addr_q <= in_addr;
          port_q <= in_port;
          if (atom_op_e'(in_op) == OP_TAS) begin
            cmp_q <= DW'(1);
            new_q <= DW'(1);
          end else begin
            cmp_q <= in_cmp;
            new_q <= in_new;
          end
          st_q <= ST_READ;
        end
        ST_READ: st_q <= ST_CMP;
        ST_CMP: begin
          old_q <= mem_rdata;
          unique case (op_q)
            OP_LOAD:  begin do_wr_q <= 1'b0; ok_q <= 1'b1; end
            OP_STORE: begin do_wr_q <= 1'b1; ok_q <= 1'b1; end
            default:  begin do_wr_q <= same; ok_q <= same; end
          endcase
          st_q <= ST_WRITE;
        end
        ST_WRITE: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign mem_rd_en = (st_q == ST_READ);
  assign mem_wr_en = (st_q == ST_WRITE) && do_wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign rsp_fire  = (st_q == ST_WRITE);
  assign rsp_port  = port_q;
  assign rsp_data  = old_q;
  assign rsp_ok    = ok_q;
endmodule

// File: rtl/atomic_cas_unit.sv
module atomic_cas_unit #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          req_valid,
  output logic [NUM_PORTS-1:0]          req_ready,
  input  logic [2*NUM_PORTS-1:0]        req_op,
  input  logic [ADDR_W*NUM_PORTS-1:0]   req_addr,
  input  logic [DATA_W*NUM_PORTS-1:0]   req_cmp,
  input  logic [DATA_W*NUM_PORTS-1:0]   req_new,
  output logic [NUM_PORTS-1:0]          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          rsp_ok
);
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS-1:0] gnt;
  logic                 idle, accept, rsp_fire;
  logic [PW-1:0]        sel_port, rsp_port;
  logic [1:0]           sel_op;
  logic [ADDR_W-1:0]    sel_addr, mem_addr;
  logic [DATA_W-1:0]    sel_cmp, sel_new, mem_wdata, mem_rdata;
  logic                 mem_rd_en, mem_wr_en;

  atom_prio_arb #(.N(NUM_PORTS)) u_arb (.req(req_valid), .gnt(gnt));

  assign req_ready = idle ? gnt : '0;
  assign accept    = |(req_valid & req_ready);

  always_comb begin
    sel_port = '0;
    sel_op   = '0;
    sel_addr = '0;
    sel_cmp  = '0;
    sel_new  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (gnt[i]) begin
        sel_port = PW'(i);
        sel_op   = req_op[2*i +: 2];
        sel_addr = req_addr[ADDR_W*i +: ADDR_W];
        sel_cmp  = req_cmp[DATA_W*i +: DATA_W];
        sel_new  = req_new[DATA_W*i +: DATA_W];
      end
    end
  end

  atom_seq #(.AW(ADDR_W), .DW(DATA_W), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_port(sel_port),
    .in_op(sel_op), .in_addr(sel_addr), .in_cmp(sel_cmp), .in_new(sel_new),
    .idle(idle), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_fire(rsp_fire), .rsp_port(rsp_port), .rsp_data(rsp_data),
    .rsp_ok(rsp_ok)
  );

  atom_word_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .rd_data(mem_rdata),
    .wr_en(mem_wr_en), .wr_addr(mem_addr), .wr_data(mem_wdata)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_rsp
    assign rsp_valid[i] = rsp_fire && (rsp_port == PW'(i));
  end
endmodule

// File: rtl/atom_checker.sv
module atom_checker #(
  parameter int NUM_PORTS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req_valid,
  input logic [NUM_PORTS-1:0] req_ready,
  input logic [NUM_PORTS-1:0] rsp_valid
);
  logic took;
  assign took = |(req_valid & req_ready);

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R7
  AST_PRIO_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && (|req_ready)) |-> req_ready[0]); // R7
  AST_LOCK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (req_ready == '0)); // R8
  AST_LOCK_DURING_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (req_ready == '0)); // R8
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    took |-> ##3 (|rsp_valid)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |=> !(|rsp_valid)); // R9
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid)); // R9
endmodule

bind atomic_cas_unit atom_checker #(.NUM_PORTS(NUM_PORTS)) i_chk (.*);

// File: tb/test_atomic_cas_unit.sv
`timescale 1ns/1ps
module test_atomic_cas_unit;
  localparam int NP = 3, AW = 4, DW = 16;
  localparam int NV = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_ready, rsp_valid;
  logic [2*NP-1:0] req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [DW*NP-1:0] req_cmp = '0, req_new = '0;
  logic [DW-1:0] rsp_data;
  logic rsp_ok;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  atomic_cas_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) i_atomic_cas_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  // fields: op[54:53] addr[52:49] cmp[48:33] new[32:17] exp_data[16:1] exp_ok[0]
  localparam logic [54:0] VEC [NV] = '{
    {2'd0, 4'd3,  16'h0000, 16'h0000, 16'h0000, 1'b1}, // R1 R5 zero after reset
    {2'd2, 4'd3,  16'h0000, 16'h00A5, 16'h0000, 1'b1}, // R2 match
    {2'd0, 4'd3,  16'h0000, 16'h0000, 16'h00A5, 1'b1}, // R2 written
    {2'd2, 4'd3,  16'h0000, 16'h0077, 16'h00A5, 1'b0}, // R3 mismatch
    {2'd0, 4'd3,  16'h0000, 16'h0000, 16'h00A5, 1'b1}, // R3 unchanged
    {2'd1, 4'd7,  16'h0000, 16'h0001, 16'h0000, 1'b1}, // R6 store
    {2'd3, 4'd7,  16'h0009, 16'h0005, 16'h0001, 1'b1}, // R4 word==1
    {2'd0, 4'd7,  16'h0000, 16'h0000, 16'h0001, 1'b1}, // R4 never holds 5
    {2'd3, 4'd3,  16'h00A5, 16'h0005, 16'h00A5, 1'b0}, // R4 word!=1
    {2'd0, 4'd3,  16'h0000, 16'h0000, 16'h00A5, 1'b1}, // R4 R5 unchanged
    {2'd1, 4'd15, 16'h0000, 16'hFFFF, 16'h0000, 1'b1}, // R6 top address
    {2'd0, 4'd15, 16'h0000, 16'h0000, 16'hFFFF, 1'b1}  // R6 R5 read back
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] c, input logic [DW-1:0] n);
    req_op[2*p +: 2]     = op;
    req_addr[AW*p +: AW] = a;
    req_cmp[DW*p +: DW]  = c;
    req_new[DW*p +: DW]  = n;
  endtask

  task automatic do_req(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] c, input logic [DW-1:0] n,
                        output logic [DW-1:0] d, output logic ok, output int lat);
    @(negedge clk);
    put(p, op, a, c, n);
    req_valid[p] = 1'b1;
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid[p] = 1'b0;
    lat = 1;
    while (!rsp_valid[p] && lat < 10) begin @(negedge clk); lat++; end
    d = rsp_data;
    ok = rsp_ok;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic ok;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, "R1 rsp idle", 32'(rsp_valid), 0);
    chk(req_ready == '0, "R1 ready idle", 32'(req_ready), 0);

    for (int k = 0; k < NV; k++) begin
      do_req(0, VEC[k][54:53], VEC[k][52:49], VEC[k][48:33], VEC[k][32:17], d, ok, lat);
      chk(d == VEC[k][16:1], $sformatf("vec%0d data (R2 R3 R4 R5 R6)", k), 32'(d), 32'(VEC[k][16:1]));
      chk(ok == VEC[k][0], $sformatf("vec%0d ok (R2 R3 R4 R5 R6)", k), 32'(ok), 32'(VEC[k][0]));
      chk(lat == 3, "R9 latency", 32'(lat), 3);
    end

    // R7 R8: ports 1 and 2 collide
    @(negedge clk);
    put(1, 2'd0, 4'd15, 16'h0, 16'h0);
    put(2, 2'd0, 4'd7, 16'h0, 16'h0);
    req_valid = 3'b110;
    #1;
    chk(req_ready == 3'b010, "R7 lowest port wins", 32'(req_ready), 32'h2);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk(req_ready == '0, "R8 locked cycle1", 32'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == '0, "R8 locked cycle2", 32'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == '0, "R8 locked cycle3", 32'(req_ready), 0);
    chk(rsp_valid == 3'b010, "R9 rsp to port1 only", 32'(rsp_valid), 32'h2);
    chk(rsp_data == 16'hFFFF, "R5 port1 data", 32'(rsp_data), 32'hFFFF);
    @(negedge clk);
    chk(rsp_valid == '0, "R9 single pulse", 32'(rsp_valid), 0);
    chk(req_ready == 3'b100, "R7 port2 next", 32'(req_ready), 32'h4);
    @(posedge clk);
    @(negedge clk);
    req_valid[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid == 3'b100, "R9 rsp to port2", 32'(rsp_valid), 32'h4);
    chk(rsp_data == 16'h0001, "R5 port2 data", 32'(rsp_data), 32'h1);

    // R2 from another port, then seen by a third
    do_req(1, 2'd2, 4'd3, 16'h00A5, 16'h0000, d, ok, lat);
    chk(d == 16'h00A5 && ok, "R2 port1 cas", 32'({ok, d}), 32'h100A5);
    do_req(2, 2'd0, 4'd3, 16'h0, 16'h0, d, ok, lat);
    chk(d == 16'h0000, "R2 port2 sees swap", 32'(d), 0);

    // R1: reset clears memory again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req(0, 2'd0, 4'd15, 16'h0, 16'h0, d, ok, lat);
    chk(d == 16'h0000, "R1 memory cleared", 32'(d), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule